// File: doc/BRIEF.md
# Byte-addressed memory target on a two-wire serial bus

This block is a serial-bus target that owns a 256-entry, 8-bit memory. It watches the clock and data wires of an I2C bus through a fast system clock, filters them through synchronizer flops and reacts to their edges. It pulls the data wire low through an open-drain enable. A controller on the bus addresses it with a 7-bit target address. The controller can then load an internal byte pointer, write a short burst of bytes, or read back any number of bytes.

A write transaction is: START, target byte with the direction bit low, pointer byte, then data bytes, then STOP. A read transaction usually first sets the pointer with a write header. It then sends a repeated START and the target byte with the direction bit high, and the target streams bytes until the controller withholds its acknowledge. How many data bytes one write may carry depends on a burst-size input, which is sampled at each START. Reads have no length cap.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, and whenever no transaction addressed to the target is open, `sda_oe_o` is 0, so the data wire is released.
- R2: The first byte after a START or repeated START is sent MSB first. Bits 7:1 are the target address and bit 0 is the direction (0 = write, 1 = read). When bits 7:1 equal `DEV_ADDR`, the target pulls the data wire low for the whole high phase of the ninth clock (ACK). When they differ, it leaves the wire high (NACK) and acknowledges nothing, and writes nothing, until the next START or STOP.
- R3: In a write, the byte after the target byte is acknowledged and loads the byte pointer. Each accepted data byte is stored at the pointer, and then the pointer increases by one, wrapping from 255 to 0.
- R4: When `page_mode_i` is 0 at the START, at most 7 data bytes of one write are acknowledged and stored. Later bytes get a NACK and change no memory. A change of `page_mode_i` after the START has no effect on that transaction.
- R5: When `page_mode_i` is 1 at the START, the cap is 8 data bytes. Later bytes get a NACK and change no memory.
- R6: In a read, each byte is taken from the pointer, sent MSB first (a 0 bit is driven as `sda_oe_o` = 1), and then the pointer increases by one with wrap. Bytes keep coming, with no count limit, for as long as the controller acknowledges.
- R7: After the controller leaves a read byte unacknowledged, the target keeps the data wire released on every further clock until the next START.
- R8: A repeated START restarts bit and byte counting and expects a new target byte. A START or STOP arriving part way through a byte discards that partial byte without storing it.
- R9: The target changes what it drives on the data wire only while the clock wire is low. During a clock high phase, the wire level seen by the controller stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock wire level |
| sda_i | input | 1 | Serial data wire level |
| page_mode_i | input | 1 | Burst-size select sampled at START (0 = 7 bytes, 1 = 8 bytes) |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data wire low |

## Verification
Two functions share one serial-clock high phase: sampling a data bit, and detecting a START or STOP condition. The bench provokes this by breaking off a data byte after four or five bits with a repeated START or a STOP. The partial byte is shifted into the same register that a completed byte would be stored from. The outcome is judged at the ports: the repeated START must draw a fresh target-byte ACK, and read-back must show that the interrupted location kept its earlier value while the bytes on either side hold what was written.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_WDATA,
        ST_RDATA
    } slv_st_e;

    // Events derived from the synchronized bus wires, valid for one clk cycle.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output i2c_mem_pkg::bus_ev_t ev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sh_d, scl_sh_q, sda_sh_d, sda_sh_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s, sda_s;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                scl_sh_d = {scl_sh_q[STAGES-2:0], scl_i};
                sda_sh_d = {sda_sh_q[STAGES-2:0], sda_i};
            end
        end else begin : g_single
            always_comb begin
                scl_sh_d = scl_i;
                sda_sh_d = sda_i;
            end
        end
    endgenerate

    // Reset to the idle bus level so no condition is seen coming out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_sh_q[LAST];
            sda_p_q  <= sda_sh_q[LAST];
        end
    end

    assign scl_s = scl_sh_q[LAST];
    assign sda_s = sda_sh_q[LAST];

    always_comb begin
        ev.start = scl_s & scl_p_q & sda_p_q & ~sda_s;
        ev.stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;
        ev.rise  = scl_s & ~scl_p_q;
        ev.fall  = ~scl_s & scl_p_q;
        ev.sda   = sda_s;
        ev.scl   = scl_s;
    end

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R3: an accepted byte is present at its location one cycle later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         NORM_LIM    = 7,
    parameter int         PAGE_LIM    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic page_mode_i,
    output logic sda_oe_o
);
    import i2c_mem_pkg::*;

    localparam int DATA_W  = 8;
    localparam int FRAME   = DATA_W + 1;
    localparam int BW      = $clog2(FRAME + 1);
    localparam int MAX_LIM = (NORM_LIM > PAGE_LIM) ? NORM_LIM : PAGE_LIM;
    localparam int CW      = $clog2(MAX_LIM + 1);
    localparam logic [CW-1:0] NORM_C = CW'(NORM_LIM);
    localparam logic [CW-1:0] PAGE_C = CW'(PAGE_LIM);
    localparam logic [BW-1:0] BYTE_DONE = BW'(DATA_W);
    localparam logic [BW-1:0] ACK_DONE  = BW'(FRAME);

    typedef struct packed {
        slv_st_e            st;
        logic [BW-1:0]      bcnt;
        logic [DATA_W-1:0]  sreg;
        logic [DATA_W-1:0]  txb;
        logic [ADDR_W-1:0]  ptr;
        logic [CW-1:0]      wcnt;
        logic               page;
        logic               acked;
        logic               mack;
        logic               oe;
    } ctl_t;

    ctl_t              c_d, c_q;
    bus_ev_t           ev;
    logic              we;
    logic [DATA_W-1:0] rdata;
    logic [CW-1:0]     lim;

    i2c_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (c_q.ptr),
        .wdata (c_q.sreg),
        .raddr (c_q.ptr),
        .rdata (rdata)
    );

    assign lim = c_q.page ? PAGE_C : NORM_C;

    always_comb begin
        c_d = c_q;
        we  = 1'b0;
        if (ev.start) begin
            c_d.st   = ST_DEV;
            c_d.bcnt = '0;
            c_d.oe   = 1'b0;
            c_d.wcnt = '0;
            c_d.page = page_mode_i;
        end else if (ev.stop) begin
            c_d.st   = ST_IDLE;
            c_d.bcnt = '0;
            c_d.oe   = 1'b0;
        end else if (c_q.st != ST_IDLE) begin
            // Rising clock: take a data bit, or the controller's ACK bit.
            if (ev.rise && c_q.bcnt < ACK_DONE) begin
                c_d.bcnt = c_q.bcnt + 1'b1;
                if (c_q.bcnt < BYTE_DONE) c_d.sreg = {c_q.sreg[DATA_W-2:0], ev.sda};
                else                      c_d.mack = ~ev.sda;
            end
            // Falling clock: the only moment the wire drive is updated.
            if (ev.fall) begin
                if (c_q.st == ST_RDATA) begin
                    if (c_q.bcnt == BYTE_DONE) begin
                        c_d.oe = 1'b0;
                    end else if (c_q.bcnt == ACK_DONE) begin
                        if (c_q.mack) begin
                            c_d.txb  = rdata;
                            c_d.ptr  = c_q.ptr + 1'b1;
                            c_d.oe   = ~rdata[DATA_W-1];
                            c_d.bcnt = '0;
                        end else begin
                            c_d.st = ST_IDLE;
                            c_d.oe = 1'b0;
                        end
                    end else if (c_q.bcnt != '0) begin
                        c_d.oe = ~c_q.txb[3'd7 - c_q.bcnt[2:0]];
                    end
                end else if (c_q.bcnt == BYTE_DONE) begin
                    c_d.acked = 1'b0;
                    unique case (c_q.st)
                        ST_DEV:  c_d.acked = (c_q.sreg[DATA_W-1:1] == DEV_ADDR);
                        ST_WORD: begin
                            c_d.acked = 1'b1;
                            c_d.ptr   = c_q.sreg[ADDR_W-1:0];
                        end
                        ST_WDATA: if (c_q.wcnt < lim) begin
                            c_d.acked = 1'b1;
                            we        = 1'b1;
                            c_d.ptr   = c_q.ptr + 1'b1;
                            c_d.wcnt  = c_q.wcnt + 1'b1;
                        end
                        default: c_d.acked = 1'b0;
                    endcase
                    c_d.oe = c_d.acked;
                end else if (c_q.bcnt == ACK_DONE) begin
                    c_d.oe   = 1'b0;
                    c_d.bcnt = '0;
                    unique case (c_q.st)
                        ST_DEV: begin
                            if (!c_q.acked) begin
                                c_d.st = ST_IDLE;
                            end else if (c_q.sreg[0]) begin
                                c_d.st  = ST_RDATA;
                                c_d.txb = rdata;
                                c_d.ptr = c_q.ptr + 1'b1;
                                c_d.oe  = ~rdata[DATA_W-1];
                            end else begin
                                c_d.st = ST_WORD;
                            end
                        end
                        ST_WORD:  c_d.st = ST_WDATA;
                        default:  c_d.st = c_q.st;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;

    // R1: no drive while no addressed transaction is open
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE) |-> !sda_oe_o);

    // R9: the drive may only be asserted from a clock-low sample
    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(ev.scl));

    // R4 / R5: the accepted-byte count never passes the cap chosen at START
    p_wcnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.wcnt <= lim);

    // R8: a START restarts framing and expects a target byte
    p_start_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> (c_q.bcnt == '0 && c_q.st == ST_DEV && c_q.wcnt == '0));

    // R8: bit counter stays inside one nine-clock frame
    p_bcnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.bcnt <= ACK_DONE);

endmodule

// File: tb/tb_i2c_mem_slave.sv
`timescale 1ns/1ps
module tb_i2c_mem_slave;
    localparam int         Q   = 6;
    localparam logic [6:0] DEV = 7'h50;

    typedef struct packed {
        logic       pg;
        logic [7:0] wa;
        logic [7:0] n;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 8'h10, 8'd3, 8'h41},
        '{1'b0, 8'h20, 8'd9, 8'h80},
        '{1'b1, 8'h40, 8'd9, 8'hC0},
        '{1'b1, 8'hFE, 8'd3, 8'h11},
        '{1'b0, 8'h60, 8'd7, 8'h5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic page = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [7:0] model [256];
    int total = 0;
    int bad = 0;
    int glitch = 0;
    bit finished = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_mem_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .page_mode_i (page),
        .sda_oe_o    (sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl = 1'b1;   waitq();
        sda_m = 1'b0; waitq();
        scl = 1'b0;   waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl = 1'b1;   waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        logic r0;
        sda_m = b; waitq();
        scl = 1'b1; waitq();
        r0 = sda_line; waitq();
        r = sda_line;
        if (r0 != r) glitch++;
        scl = 1'b0; waitq();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        logic r;
        for (int i = 0; i < n; i++) clk_bit(v[7-i], r);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic r;
        send_bits(v, 8);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            d = {d[6:0], r};
        end
        clk_bit(~mack, r);
    endtask

    // Sets the pointer, re-starts in read direction, checks n bytes against the model.
    task automatic read_seq(input logic [7:0] addr, input int n, input string tag);
        logic ack;
        logic r;
        logic [7:0] d;
        bus_start();
        wr_byte({DEV, 1'b0}, ack); chk("R2 target ack", ack, 1);
        wr_byte(addr, ack);        chk("R3 pointer ack", ack, 1);
        bus_start();
        wr_byte({DEV, 1'b1}, ack); chk("R8 ack after repeated start", ack, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i < n - 1, d);
            chk(tag, d, model[8'(addr + i)]);
        end
        clk_bit(1'b1, r); chk("R7 released after nack", r, 1);
        clk_bit(1'b1, r); chk("R7 released after nack", r, 1);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int lim;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 reset drive", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle drive", sda_oe, 0);

        // Table walk: bursts in both modes, caps, pointer wrap, read-back.
        for (int v = 0; v < 5; v++) begin
            page = VECS[v].pg;
            lim = VECS[v].pg ? 8 : 7;
            bus_start();
            wr_byte({DEV, 1'b0}, ack); chk("R2 target ack", ack, 1);
            wr_byte(VECS[v].wa, ack);  chk("R3 pointer ack", ack, 1);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                wr_byte(8'(VECS[v].seed + i), ack);
                chk(VECS[v].pg ? "R5 page cap" : "R4 normal cap", ack, (i < lim) ? 1 : 0);
                if (i < lim) model[8'(VECS[v].wa + i)] = 8'(VECS[v].seed + i);
            end
            bus_stop();
            chk("R1 released after stop", sda_oe, 0);
            read_seq(VECS[v].wa,
                     ((int'(VECS[v].n) < lim) ? int'(VECS[v].n) : lim) + 1,
                     "R3 R6 read-back");
        end
        page = 1'b0;

        // R2: wrong target address, following bytes ignored.
        bus_start();
        wr_byte({7'h51, 1'b0}, ack); chk("R2 mismatch nack", ack, 0);
        wr_byte(8'h00, ack);         chk("R2 ignored byte", ack, 0);
        wr_byte(8'hEE, ack);         chk("R2 ignored byte", ack, 0);
        bus_stop();
        read_seq(8'h00, 1, "R2 memory unchanged");

        // R4: burst size taken at START, later change of the input ignored.
        page = 1'b0;
        bus_start();
        page = 1'b1;
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'hA0, ack);
        for (int i = 0; i < 8; i++) begin
            wr_byte(8'(8'h90 + i), ack);
            chk("R4 mode sampled at start", ack, (i < 7) ? 1 : 0);
            if (i < 7) model[8'(8'hA0 + i)] = 8'(8'h90 + i);
        end
        bus_stop();
        page = 1'b0;
        read_seq(8'hA0, 8, "R4 eighth byte not stored");

        // R8: repeated START breaks off a byte after four bits.
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h80, ack);
        send_bits(8'hAA, 4);
        bus_start();
        wr_byte({DEV, 1'b0}, ack); chk("R8 fresh target byte", ack, 1);
        wr_byte(8'h81, ack);
        wr_byte(8'h33, ack);       chk("R8 data after restart", ack, 1);
        model[8'h81] = 8'h33;
        bus_stop();
        read_seq(8'h80, 2, "R8 partial byte dropped");

        // R8: STOP breaks off a byte after five bits.
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h90, ack);
        wr_byte(8'h77, ack); chk("R3 data ack", ack, 1);
        model[8'h90] = 8'h77;
        send_bits(8'h55, 5);
        bus_stop();
        read_seq(8'h90, 2, "R8 stop drops partial byte");

        // R6: long read wrapping past the top of the array.
        read_seq(8'hF8, 20, "R6 unlimited read with wrap");

        chk("R9 wire stable while clock high", glitch, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule